// File: doc/BRIEF.md
# Relevance-Ranked Cluster Fetch Planner

This block keeps a table of key clusters for an attention engine that computes next to memory. Each entry holds a centroid vector and the place in DRAM where that cluster's rows live. Clusters are added one at a time on a registration stream. The block gives a cluster its bank by rotating through the banks. Within that bank, the cluster takes the next run of free rows, so its rows are contiguous.

When a query vector arrives, the block scores every registered centroid with a signed dot product, one cluster per clock. While it scores, it keeps a running ranked list of the best candidates. It then sends out one fetch descriptor for each selected cluster. A descriptor carries the cluster, bank, first row, row count and score. Descriptors leave in order of falling score, and a one-cycle `done` pulse closes the list. Clusters that are not selected produce no descriptor, so the memory sees no activity for them.

All three streams use valid/ready. A transfer happens on a clock edge where both valid and ready are high. While the sink holds `d_ready` low, `d_valid` and the whole descriptor stay unchanged. A query is accepted only while the block is idle. Registration is refused while a query is pending or being served, and once the table is full. A pending query wins over a registration in the same cycle.

Top module: `cluster_selector`

## Requirements
- R1: The k-th registration accepted after reset (k from 0) becomes cluster k, and it is placed in bank k mod 4.
- R2: Each bank has a next-free-row cursor that starts at 0 after reset. A new cluster's start row is its bank's cursor, and the cursor then advances by the cluster's row count.
- R3: A cluster's score is the exact dot product of the query with its centroid, both being 16 signed 8-bit elements packed with element j at bits [8j+7:8j]. The score is given as a 24-bit two's-complement value, and it is exact at the extreme of all elements equal to -128.
- R4: A query produces exactly min(N, registered clusters) descriptors. N is `sel_n`, sampled when the query is accepted: 0 is taken as 1 and values above 8 are taken as 8.
- R5: Descriptors come out in falling score order. Equal scores go out lower cluster index first.
- R6: Only the selected clusters appear in descriptors. A query with no registered clusters gives no descriptor, only `done`.
- R7: While `d_valid` is high and `d_ready` is low, `d_valid` and every descriptor field stay unchanged on the next cycle.
- R8: `done` is high for exactly one cycle, on the cycle after the last descriptor transfer (or on the cycle after acceptance if the table is empty). `d_valid` is low while `done` is high.
- R9: `q_ready` is high only while idle. `reg_ready` is low while a query is being served, while `q_valid` is high, and once 32 clusters are registered. Registration attempts in those conditions are not taken.
- R10: After reset, `q_ready` and `reg_ready` are high, and `d_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_n | input | 4 | Number of clusters to select, sampled at query acceptance |
| reg_valid | input | 1 | Registration request valid |
| reg_ready | output | 1 | Registration can be accepted |
| reg_centroid | input | 128 | Centroid of the cluster being registered |
| reg_rows | input | 6 | Row count of the cluster being registered |
| q_valid | input | 1 | Query valid |
| q_ready | output | 1 | Query can be accepted (idle) |
| q_vec | input | 128 | Query vector |
| d_valid | output | 1 | Descriptor valid |
| d_ready | input | 1 | Descriptor sink ready |
| d_cluster | output | 5 | Selected cluster index |
| d_bank | output | 2 | Bank of the cluster |
| d_row | output | 12 | First row of the cluster in its bank |
| d_rows | output | 6 | Number of contiguous rows to fetch |
| d_score | output | 24 | Signed relevance score |
| done | output | 1 | One-cycle end-of-list pulse |

## Verification
The hardest situations to reach are a descriptor stalled in the middle of a ranked list, and equal scores between clusters that are far apart in index. The stimulus registers a duplicate of an earlier centroid, and it issues an all-zero query that makes every score equal. It then drains the lists with a repeating pattern of low `d_ready`, and checks each stalled cycle for a held descriptor. Filling all 32 slots exposes the refusal of extra registrations, and the final query checks row cursors that have advanced through several clusters per bank.

// File: rtl/clsel_pkg.sv
`timescale 1ns/1ps
package clsel_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCORE,
    ST_EMIT,
    ST_FIN
  } sel_state_t;
endpackage

// File: rtl/dot_unit.sv
`timescale 1ns/1ps
module dot_unit #(
  parameter int DIM = 16,
  parameter int EW  = 8,
  parameter int SW  = 24
) (
  input  logic [DIM*EW-1:0]  a,
  input  logic [DIM*EW-1:0]  b,
  output logic signed [SW-1:0] y
);
  logic signed [2*EW-1:0] prod [DIM];

  for (genvar g = 0; g < DIM; g++) begin : g_mul
    assign prod[g] = $signed(a[g*EW +: EW]) * $signed(b[g*EW +: EW]);
  end

  always_comb begin
    y = '0;
    for (int j = 0; j < DIM; j++) y = y + SW'(prod[j]);
  end
endmodule

// File: rtl/topn_list.sv
`timescale 1ns/1ps
module topn_list #(
  parameter int K  = 8,
  parameter int SW = 24,
  parameter int IW = 5,
  localparam int KW = (K > 1) ? $clog2(K) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 ins,
  input  logic signed [SW-1:0] ins_score,
  input  logic [IW-1:0]        ins_idx,
  input  logic [KW-1:0]        rd_pos,
  output logic signed [SW-1:0] rd_score,
  output logic [IW-1:0]        rd_idx
);
  logic [K-1:0]          v;
  logic [K-1:0]          gt;
  logic signed [SW-1:0]  s  [K];
  logic [IW-1:0]         ix [K];

  // Strictly greater only: an equal newcomer (higher index) lands behind.
  for (genvar p = 0; p < K; p++) begin : g_slot
    assign gt[p] = !v[p] || (ins_score > s[p]);
    if (p == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
          v[p] <= 1'b0; s[p] <= '0; ix[p] <= '0;
        end else if (ins && gt[p]) begin
          v[p] <= 1'b1; s[p] <= ins_score; ix[p] <= ins_idx;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
          v[p] <= 1'b0; s[p] <= '0; ix[p] <= '0;
        end else if (ins && gt[p]) begin
          if (!gt[p-1]) begin
            v[p] <= 1'b1; s[p] <= ins_score; ix[p] <= ins_idx;
          end else begin
            v[p] <= v[p-1]; s[p] <= s[p-1]; ix[p] <= ix[p-1];
          end
        end
      end
    end
  end

  assign rd_score = s[rd_pos];
  assign rd_idx   = ix[rd_pos];
endmodule

// File: rtl/cluster_table.sv
`timescale 1ns/1ps
module cluster_table #(
  parameter int DIM   = 16,
  parameter int EW    = 8,
  parameter int NCLU  = 32,
  parameter int NBANK = 4,
  parameter int ROWW  = 12,
  parameter int RCW   = 6,
  localparam int VW = DIM*EW,
  localparam int IW = $clog2(NCLU),
  localparam int CW = $clog2(NCLU+1),
  localparam int BW = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [VW-1:0]   wr_vec,
  input  logic [RCW-1:0]  wr_rows,
  output logic [CW-1:0]   cnt,
  output logic            full,
  input  logic [IW-1:0]   sc_idx,
  output logic [VW-1:0]   sc_vec,
  input  logic [IW-1:0]   dd_idx,
  output logic [BW-1:0]   dd_bank,
  output logic [ROWW-1:0] dd_row,
  output logic [RCW-1:0]  dd_rows
);
  logic [VW-1:0]   cmem [NCLU];
  logic [BW-1:0]   bmem [NCLU];
  logic [ROWW-1:0] rmem [NCLU];
  logic [RCW-1:0]  nmem [NCLU];
  logic [ROWW-1:0] cur  [NBANK];
  logic [BW-1:0]   rr;

  assign full = (cnt == CW'(NCLU));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      rr  <= '0;
    end else if (wr_en) begin
      cnt <= cnt + CW'(1);
      rr  <= (rr == BW'(NBANK-1)) ? '0 : rr + BW'(1);
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_cursor
    always_ff @(posedge clk) begin
      if (!rst_n) cur[b] <= '0;
      else if (wr_en && rr == BW'(b)) cur[b] <= cur[b] + ROWW'(wr_rows);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      cmem[cnt[IW-1:0]] <= wr_vec;
      bmem[cnt[IW-1:0]] <= rr;
      rmem[cnt[IW-1:0]] <= cur[rr];
      nmem[cnt[IW-1:0]] <= wr_rows;
    end
  end

  assign sc_vec  = cmem[sc_idx];
  assign dd_bank = bmem[dd_idx];
  assign dd_row  = rmem[dd_idx];
  assign dd_rows = nmem[dd_idx];
endmodule

// File: rtl/cluster_selector.sv
`timescale 1ns/1ps
module cluster_selector
  import clsel_pkg::*;
#(
  parameter int DIM    = 16,
  parameter int EW     = 8,
  parameter int SW     = 24,
  parameter int NCLU   = 32,
  parameter int NBANK  = 4,
  parameter int ROWW   = 12,
  parameter int RCW    = 6,
  parameter int MAXSEL = 8,
  localparam int VW   = DIM*EW,
  localparam int IW   = $clog2(NCLU),
  localparam int CW   = $clog2(NCLU+1),
  localparam int BW   = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int SELW = $clog2(MAXSEL+1),
  localparam int KW   = (MAXSEL > 1) ? $clog2(MAXSEL) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SELW-1:0] sel_n,
  input  logic            reg_valid,
  output logic            reg_ready,
  input  logic [VW-1:0]   reg_centroid,
  input  logic [RCW-1:0]  reg_rows,
  input  logic            q_valid,
  output logic            q_ready,
  input  logic [VW-1:0]   q_vec,
  output logic            d_valid,
  input  logic            d_ready,
  output logic [IW-1:0]   d_cluster,
  output logic [BW-1:0]   d_bank,
  output logic [ROWW-1:0] d_row,
  output logic [RCW-1:0]  d_rows,
  output logic [SW-1:0]   d_score,
  output logic            done
);
  sel_state_t           st;
  logic [VW-1:0]        qv_r;
  logic [SELW-1:0]      nsel_r, nsel_in;
  logic [IW-1:0]        sidx;
  logic [CW-1:0]        eptr, emit_n, cnt;
  logic                 full, wr_en, q_go, emit_last;
  logic [VW-1:0]        sc_vec;
  logic signed [SW-1:0] dot_y, top_score;
  logic [IW-1:0]        top_idx;

  assign q_ready   = (st == ST_IDLE);
  assign reg_ready = (st == ST_IDLE) && !q_valid && !full;
  assign wr_en     = reg_valid && reg_ready;
  assign q_go      = q_valid && q_ready;
  assign d_valid   = (st == ST_EMIT);
  assign done      = (st == ST_FIN);

  always_comb begin
    if (sel_n == '0)                nsel_in = SELW'(1);
    else if (sel_n > SELW'(MAXSEL)) nsel_in = SELW'(MAXSEL);
    else                            nsel_in = sel_n;
  end

  assign emit_n    = (cnt < CW'(nsel_r)) ? cnt : CW'(nsel_r);
  assign emit_last = ((eptr + CW'(1)) == emit_n);

  cluster_table #(
    .DIM(DIM), .EW(EW), .NCLU(NCLU), .NBANK(NBANK), .ROWW(ROWW), .RCW(RCW)
  ) u_table (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_vec(reg_centroid),
    .wr_rows(reg_rows), .cnt(cnt), .full(full), .sc_idx(sidx),
    .sc_vec(sc_vec), .dd_idx(top_idx), .dd_bank(d_bank), .dd_row(d_row),
    .dd_rows(d_rows)
  );

  dot_unit #(.DIM(DIM), .EW(EW), .SW(SW)) u_dot (
    .a(qv_r), .b(sc_vec), .y(dot_y)
  );

  topn_list #(.K(MAXSEL), .SW(SW), .IW(IW)) u_rank (
    .clk(clk), .rst_n(rst_n), .clr(q_go), .ins(st == ST_SCORE),
    .ins_score(dot_y), .ins_idx(sidx), .rd_pos(eptr[KW-1:0]),
    .rd_score(top_score), .rd_idx(top_idx)
  );

  assign d_cluster = top_idx;
  assign d_score   = top_score;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      qv_r   <= '0;
      nsel_r <= SELW'(1);
      sidx   <= '0;
      eptr   <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (q_go) begin
          qv_r   <= q_vec;
          nsel_r <= nsel_in;
          sidx   <= '0;
          st     <= (cnt == '0) ? ST_FIN : ST_SCORE;
        end
        ST_SCORE: begin
          if ((CW'(sidx) + CW'(1)) == cnt) begin
            st   <= ST_EMIT;
            eptr <= '0;
          end else begin
            sidx <= sidx + IW'(1);
          end
        end
        ST_EMIT: if (d_ready) begin
          if (emit_last) st <= ST_FIN;
          else           eptr <= eptr + CW'(1);
        end
        ST_FIN: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cluster_selector_chk.sv
`timescale 1ns/1ps
module cluster_selector_chk #(
  parameter int SW    = 24,
  parameter int NCLU  = 32,
  parameter int NBANK = 4,
  parameter int ROWW  = 12,
  parameter int RCW   = 6,
  localparam int IW = $clog2(NCLU),
  localparam int CW = $clog2(NCLU+1),
  localparam int BW = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_valid,
  input logic            reg_ready,
  input logic            q_ready,
  input logic            d_valid,
  input logic            d_ready,
  input logic [IW-1:0]   d_cluster,
  input logic [BW-1:0]   d_bank,
  input logic [ROWW-1:0] d_row,
  input logic [RCW-1:0]  d_rows,
  input logic [SW-1:0]   d_score,
  input logic            done
);
  logic [CW-1:0]  reg_seen;
  logic           have_prev;
  logic [SW-1:0]  prev_score;
  logic [IW-1:0]  prev_cluster;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_seen <= '0; have_prev <= 1'b0; prev_score <= '0; prev_cluster <= '0;
    end else begin
      if (reg_valid && reg_ready) reg_seen <= reg_seen + CW'(1);
      if (done) have_prev <= 1'b0;
      else if (d_valid && d_ready) begin
        have_prev <= 1'b1; prev_score <= d_score; prev_cluster <= d_cluster;
      end
    end
  end

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    d_valid && !d_ready |=> d_valid && $stable(d_cluster) && $stable(d_bank)
      && $stable(d_row) && $stable(d_rows) && $stable(d_score));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !d_valid);
  // R5
  desc_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    d_valid && have_prev |-> $signed(d_score) <= $signed(prev_score));
  // R5
  tie_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    d_valid && have_prev && d_score == prev_score |-> d_cluster > prev_cluster);
  // R1
  bank_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    d_valid |-> 32'(d_bank) == (32'(d_cluster) % NBANK));
  // R9
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    d_valid |-> !q_ready && !reg_ready);
  // R9
  table_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_seen == CW'(NCLU) |-> !reg_ready);
endmodule

bind cluster_selector cluster_selector_chk #(
  .SW(SW), .NCLU(NCLU), .NBANK(NBANK), .ROWW(ROWW), .RCW(RCW)
) u_chk (.*);

// File: tb/cluster_selector_test.sv
`timescale 1ns/1ps
module cluster_selector_test;
  localparam int VW = 128;

  typedef struct packed {
    logic [7:0] base;
    logic [7:0] step;
    logic [3:0] n;
    logic [3:0] ecnt;
  } qrow_t;

  // query element j = base + step*j (8-bit wrap); ecnt = expected descriptor count with 12 clusters
  localparam qrow_t QTAB [8] = '{
    '{8'h80, 8'h00, 4'd3,  4'd3},
    '{8'h05, 8'h03, 4'd8,  4'd8},
    '{8'hF0, 8'h07, 4'd0,  4'd1},
    '{8'h11, 8'hFD, 4'd15, 4'd8},
    '{8'h01, 8'h01, 4'd5,  4'd5},
    '{8'hC3, 8'h13, 4'd2,  4'd2},
    '{8'h7F, 8'h00, 4'd4,  4'd4},
    '{8'h00, 8'h00, 4'd6,  4'd6}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] sel_n = '0;
  logic reg_valid = 1'b0, q_valid = 1'b0, d_ready = 1'b1;
  logic [VW-1:0] reg_centroid = '0, q_vec = '0;
  logic [5:0] reg_rows = '0;
  logic reg_ready, q_ready, d_valid, done;
  logic [4:0] d_cluster;
  logic [1:0] d_bank;
  logic [11:0] d_row;
  logic [5:0] d_rows;
  logic [23:0] d_score;

  int nvec = 0, nfail = 0, cyc = 0, regcnt = 0;
  logic signed [7:0] mc [32][16];
  int mbank [32], mrow [32], mrows [32], cur [4];

  always #5 clk = ~clk;

  cluster_selector uut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .reg_valid(reg_valid),
    .reg_ready(reg_ready), .reg_centroid(reg_centroid), .reg_rows(reg_rows),
    .q_valid(q_valid), .q_ready(q_ready), .q_vec(q_vec), .d_valid(d_valid),
    .d_ready(d_ready), .d_cluster(d_cluster), .d_bank(d_bank), .d_row(d_row),
    .d_rows(d_rows), .d_score(d_score), .done(done)
  );

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nvec++; nfail++;
      $display("FAIL watchdog actual=%0d expected<150000 cycles", cyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic signed [7:0] cgen(int i, int j);
    int ii;
    if (i == 10) return -8'sd128;
    ii = (i == 11) ? 3 : i;
    return 8'(((ii*37 + j*11 + ii*j*3) % 201) - 100);
  endfunction

  function automatic logic [VW-1:0] mkq(logic [7:0] base, logic [7:0] step);
    logic [VW-1:0] v;
    for (int j = 0; j < 16; j++) v[j*8 +: 8] = 8'(base + step*8'(j));
    return v;
  endfunction

  function automatic logic [VW-1:0] cvec(int i);
    logic [VW-1:0] v;
    for (int j = 0; j < 16; j++) v[j*8 +: 8] = cgen(i, j);
    return v;
  endfunction

  task automatic add_cluster(input int i);
    for (int j = 0; j < 16; j++) mc[i][j] = cgen(i, j);
    mrows[i] = (i % 4) + 1;
    mbank[i] = i % 4;
    mrow[i]  = cur[i % 4];
    cur[i % 4] += mrows[i];
    @(negedge clk);
    reg_centroid = cvec(i);
    reg_rows = 6'(mrows[i]);
    reg_valid = 1'b1;
    while (!reg_ready) @(negedge clk);
    @(negedge clk);
    reg_valid = 1'b0;
    regcnt++;
  endtask

  task automatic run_query(input logic [VW-1:0] qv, input int n, input int ecnt, input bit stall);
    int ms [32];
    bit used [32];
    int eidx [8];
    int m, got, k, best;
    bit stalled;
    longint saved, act, exp;
    m = (n == 0) ? 1 : ((n > 8) ? 8 : n);
    if (regcnt < m) m = regcnt;
    for (int i = 0; i < regcnt; i++) begin
      ms[i] = 0; used[i] = 1'b0;
      for (int j = 0; j < 16; j++) ms[i] += int'($signed(qv[j*8 +: 8])) * int'(mc[i][j]);
    end
    for (int r = 0; r < m; r++) begin
      best = -1;
      for (int i = 0; i < regcnt; i++)
        if (!used[i] && (best < 0 || ms[i] > ms[best])) best = i;
      used[best] = 1'b1;
      eidx[r] = best;
    end
    @(negedge clk);
    q_vec = qv; sel_n = 4'(n); q_valid = 1'b1;
    while (!q_ready) @(negedge clk);
    @(negedge clk);
    q_valid = 1'b0;
    if (!done) chk(!q_ready, "R9 busy q_ready", longint'(q_ready), 0);
    got = 0; k = 0; stalled = 1'b0; saved = 0;
    while (1) begin
      act = {d_cluster, d_bank, d_row, d_rows, d_score};
      if (stalled) chk(d_valid && act == saved, "R7 stall hold", act, saved);
      if (done) break;
      d_ready = stall ? ((k % 3) != 1) : 1'b1;
      k++;
      stalled = 1'b0;
      if (d_valid && d_ready) begin
        if (got < m) begin
          best = eidx[got];
          exp = {5'(best), 2'(mbank[best]), 12'(mrow[best]), 6'(mrows[best]), 24'(ms[best])};
          chk(act == exp, "R1 R2 R3 R5 R6 descriptor", act, exp);
        end else begin
          chk(1'b0, "R6 extra descriptor", act, 0);
        end
        got++;
      end else if (d_valid) begin
        stalled = 1'b1; saved = act;
      end
      @(negedge clk);
    end
    chk(got == ecnt, "R4 descriptor count", got, ecnt);
    d_ready = 1'b1;
    @(negedge clk);
    chk(!done, "R8 done single cycle", longint'(done), 0);
  endtask

  initial begin
    for (int b = 0; b < 4; b++) cur[b] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(q_ready && reg_ready && !d_valid && !done, "R10 reset state",
        {q_ready, reg_ready, d_valid, done}, 4'b1100);
    // R6 R8: empty table gives done only
    run_query(mkq(8'h10, 8'h01), 3, 0, 1'b0);
    for (int i = 0; i < 12; i++) add_cluster(i);
    for (int e = 0; e < 8; e++)
      run_query(mkq(QTAB[e].base, QTAB[e].step), int'(QTAB[e].n), int'(QTAB[e].ecnt), e[0]);
    // R5 tie: cluster 11 duplicates cluster 3
    run_query(cvec(3), 8, 8, 1'b1);
    for (int i = 12; i < 32; i++) add_cluster(i);
    @(negedge clk);
    chk(!reg_ready, "R9 full table", longint'(reg_ready), 0);
    reg_valid = 1'b1;
    for (int t = 0; t < 3; t++) begin
      @(negedge clk);
      chk(!reg_ready, "R9 extra registration refused", longint'(reg_ready), 0);
    end
    reg_valid = 1'b0;
    // R2 cursors advanced over many clusters per bank
    run_query(cvec(30), 8, 8, 1'b1);
    run_query(mkq(8'h00, 8'h00), 8, 8, 1'b0);
    summary();
  end
endmodule